// File: doc/BRIEF.md
# Sample Gain and Offset Corrector

This block corrects a stream of signed 24-bit conversion results. Each accepted sample is first multiplied by a programmable gain and then shifted by a programmable offset. The result is clamped to the signed 24-bit range. The gain is an unsigned 16-bit code in 1.15 fixed point, so code 0x8000 is a gain of exactly one. The offset is a 16-bit two's-complement code. Its whole range covers a small band around zero, and one offset step equals two output steps.

Both coefficients are held in registers inside the block and are written through a simple port. That port has an enable, a one-bit select and a 16-bit data word. A corrected sample leaves the block exactly two clock cycles after it was accepted. The block accepts a new sample on every cycle. Each sample is computed with the coefficients that were in force when it entered.

Top module: `gain_offset_corr`

## Requirements
- R1: After reset the gain code is 0xA000 (a gain of 1.25), the offset code is 0x0000 and `outValid` is low.
- R2: With gain code 0x8000 and offset 0, every input sample is delivered unchanged, including 0x7FFFFF and 0x800000.
- R3: The gain product is `sample * gain`. It is divided by 2^15 and rounded half up, so 1.5 becomes 2, -1.5 becomes -1 and -0.5 becomes 0.
- R4: The offset is added after the rounded gain product. It is sign-extended and weighted by two output LSBs: out = round(sample*gain/2^15) + 2*offset.
- R5: A result above 0x7FFFFF is output as 0x7FFFFF and never wraps.
- R6: A result below -2^23 is output as 0x800000 and never wraps.
- R7: `outValid` is high exactly two clock cycles after each cycle in which `inValid` was high, and at no other time.
- R8: A coefficient write takes effect from the next sample accepted after it. A sample accepted in the same cycle as a write uses the old value. A sample already in the pipeline keeps its coefficients.
- R9: When `regWrEn` is high, select 0 writes the gain and select 1 writes the offset. A write produces no output sample of its own.
- R10: With the default gain, an input at 80% of full scale (0x666666) produces full-scale output 0x7FFFFF.
- R11: Samples presented on consecutive cycles are each corrected, in order, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 24 | Signed input sample |
| regWrEn | input | 1 | Coefficient write enable |
| regWrSel | input | 1 | Write target: 0 selects gain, 1 selects offset |
| regWrData | input | 16 | Coefficient value to write |
| outValid | output | 1 | Corrected sample strobe |
| outSample | output | 24 | Corrected, saturated signed sample |

## Verification
A coefficient write and a sample acceptance can occur in the same cycle. In that case the sample must be computed with the value the register held before the write. The bench provokes this by driving `regWrEn` together with `inValid`, sometimes on every cycle of a burst. In its model, the bench computes the sample's expected value before it applies the write. A wrong ordering therefore shows up as a value mismatch on that very sample, while the following sample confirms that the new coefficient has arrived.

// File: rtl/goc_pkg.sv
package goc_pkg;

  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic loadGain;    // write the gain register
    logic loadOffset;  // write the offset register
    logic capture;     // take a new sample into stage one
    logic emit;        // move stage one into the output register
  } goc_strobe_t;

endpackage

// File: rtl/goc_control.sv
module goc_control
  import goc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        regWrEn,
  input  logic        regWrSel,
  output goc_strobe_t strobe,
  output logic        outValid
);

  logic midValid;

  always_comb begin
    strobe.loadGain   = regWrEn && !regWrSel;
    strobe.loadOffset = regWrEn && regWrSel;
    strobe.capture    = inValid;
    strobe.emit       = midValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  // R7
  mid_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> midValid);

  // R7
  mid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !midValid);

  // R7
  out_follows_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    midValid |=> outValid);

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadGain, strobe.loadOffset}) <= 1);

endmodule

// File: rtl/goc_datapath.sv
module goc_datapath
  import goc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int COEF_W   = 16,
  parameter int FRAC_W   = 15,
  parameter int OFF_SHIFT = 1,
  parameter logic [COEF_W-1:0] GAIN_RESET = 16'hA000,
  parameter logic [COEF_W-1:0] OFFSET_RESET = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  goc_strobe_t         strobe,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [COEF_W-1:0]   regWrData,
  output logic [SAMPLE_W-1:0] outSample
);

  localparam int PROD_W = SAMPLE_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] SUM_MAX =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] SUM_MIN =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [COEF_W-1:0]        gainReg;
  logic [COEF_W-1:0]        offsetReg;
  logic signed [PROD_W-1:0] prodQ;
  logic [COEF_W-1:0]        offsetSnap;

  logic signed [PROD_W-1:0] prodNext;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] scaled;
  logic signed [PROD_W-1:0] offsetExt;
  logic signed [PROD_W-1:0] sumWide;
  logic [SAMPLE_W-1:0]      satNext;

  // Coefficient registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainReg   <= GAIN_RESET;
      offsetReg <= OFFSET_RESET;
    end else begin
      if (strobe.loadGain)   gainReg   <= regWrData;
      if (strobe.loadOffset) offsetReg <= regWrData;
    end
  end

  // Stage one: full-precision product, coefficient snapshot
  always_comb begin
    prodNext = $signed(inSample) * $signed({1'b0, gainReg});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ      <= '0;
      offsetSnap <= '0;
    end else if (strobe.capture) begin
      prodQ      <= prodNext;
      offsetSnap <= offsetReg;
    end
  end

  // Stage two: round, add weighted offset, clamp
  always_comb begin
    biased    = prodQ + ROUND_BIAS;
    scaled    = biased >>> FRAC_W;
    offsetExt = $signed({{(PROD_W-COEF_W){offsetSnap[COEF_W-1]}}, offsetSnap}) <<< OFF_SHIFT;
    sumWide   = scaled + offsetExt;
    if (sumWide > SUM_MAX)      satNext = OUT_MAX;
    else if (sumWide < SUM_MIN) satNext = OUT_MIN;
    else                        satNext = sumWide[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outSample <= '0;
    else if (strobe.emit) outSample <= satNext;
  end

  // R5
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && sumWide > SUM_MAX) |=> outSample == OUT_MAX);

  // R6
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && sumWide < SUM_MIN) |=> outSample == OUT_MIN);

  // R8
  snap_old_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> offsetSnap == $past(offsetReg));

  // R9
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadGain |=> $stable(gainReg));

  // R9
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOffset |=> $stable(offsetReg));

endmodule

// File: rtl/gain_offset_corr.sv
module gain_offset_corr
  import goc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int COEF_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                regWrEn,
  input  logic                regWrSel,
  input  logic [COEF_W-1:0]   regWrData,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);

  goc_strobe_t strobe;

  goc_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  goc_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSample  (inSample),
    .regWrData (regWrData),
    .outSample (outSample)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: tb/gain_offset_corr_bench.sv
module gain_offset_corr_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inSample = '0;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic        outValid;
  logic [23:0] outSample;

  always #4 clk = ~clk;

  gain_offset_corr u_gain_offset_corr (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .outValid(outValid), .outSample(outSample)
  );

  typedef struct {
    logic [23:0] expVal;
    int          issue;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  int          checks = 0;
  int          fails = 0;
  int          posCnt = 0;
  bit          done = 0;
  logic [15:0] mGain = 16'hA000;
  logic [15:0] mOff  = 16'h0000;

  always @(posedge clk) posCnt++;

  function automatic logic [23:0] model(logic [23:0] x, logic [15:0] g, logic [15:0] o);
    longint p, r, s;
    p = longint'($signed(x)) * longint'(g);
    r = (p + 64'sd16384) >>> 15;
    s = r + 2 * longint'($signed(o));
    if (s > 64'sd8388607)       return 24'h7FFFFF;
    else if (s < -64'sd8388608) return 24'h800000;
    else                        return s[23:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Driver: one cycle of stimulus; the sample uses the coefficients in force
  task automatic drive(bit v, logic [23:0] x, bit w, bit sel, logic [15:0] d, string tag);
    item_t it;
    @(negedge clk);
    inValid = v; inSample = x; regWrEn = w; regWrSel = sel; regWrData = d;
    if (v) begin
      it.expVal = model(x, mGain, mOff);
      it.issue  = posCnt + 1;
      it.tag    = tag;
      sbQ.push_back(it);
    end
    if (w) begin
      if (sel) mOff = d; else mGain = d;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, '0, "");
  endtask

  task automatic sample(logic [23:0] x, string tag);
    drive(1, x, 0, 0, '0, tag);
  endtask

  task automatic write(bit sel, logic [15:0] d);
    drive(0, '0, 1, sel, d, "");
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check("R9 unexpected outValid", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        check(it.tag, {8'h0, outSample}, {8'h0, it.expVal});
        check("R7 latency", posCnt - it.issue, 32'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid low in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid low after reset", {31'd0, outValid}, 32'd0);

    // R1 defaults, R10 80% input reaches full scale
    sample(24'h100000, "R1 default gain 1.25");
    sample(24'h666666, "R10 80pct to full scale");
    sample(24'h99999A, "R10 negative 80pct");
    idle(3);

    // R2 unity gain passes samples
    write(0, 16'h8000);
    sample(24'd1234, "R2 unity positive");
    sample(24'hFFFFFB, "R2 unity negative");
    sample(24'h7FFFFF, "R2 unity max");
    sample(24'h800000, "R2 unity min");
    idle(3);

    // R3 rounding half up at gain 0.5
    write(0, 16'h4000);
    sample(24'd3, "R3 1.5 to 2");
    sample(24'hFFFFFD, "R3 -1.5 to -1");
    sample(24'd5, "R3 2.5 to 3");
    sample(24'hFFFFFF, "R3 -0.5 to 0");
    idle(3);

    // R4 offset after gain, two LSB weight
    write(0, 16'h8000);
    write(1, 16'h0010);
    sample(24'd0, "R4 offset +16 -> +32");
    write(1, 16'hFFFF);
    sample(24'd100, "R4 offset -1 -> -2");
    write(0, 16'hC000);
    write(1, 16'h0100);
    sample(24'd1000, "R4 gain then offset");
    idle(3);

    // R5 / R6 saturation
    write(1, 16'h0000);
    write(0, 16'hFFFF);
    sample(24'h7FFFFF, "R5 gain overflow high");
    sample(24'h800000, "R6 gain overflow low");
    write(0, 16'h8000);
    write(1, 16'h7FFF);
    sample(24'h7FFF00, "R5 offset overflow high");
    write(1, 16'h8000);
    sample(24'h800010, "R6 offset overflow low");
    idle(3);

    // R8 write in the same cycle as a sample
    write(1, 16'h0000);
    drive(1, 24'd500, 1, 0, 16'h4000, "R8 same-cycle uses old gain");
    sample(24'd500, "R8 next sample uses new gain");
    drive(1, 24'd500, 1, 1, 16'h0020, "R8 same-cycle uses old offset");
    sample(24'd500, "R8 next sample uses new offset");
    idle(3);

    // R9 writes alone yield no output; select routes correctly
    write(1, 16'h0000);
    write(0, 16'h8000);
    idle(4);
    check("R9 no output from writes", {31'd0, outValid}, 32'd0);
    write(1, 16'h0003);
    sample(24'd10, "R9 select 1 hits offset only");
    idle(3);

    // R11 back-to-back burst with writes interleaved
    for (int i = 0; i < 24; i++) begin
      drive(1, 24'(i * 24'h05A3C1 + 24'h811111), (i % 3) == 0, (i % 2) == 1,
            16'(16'h7000 + i * 16'h0931), "R11 burst");
    end
    idle(5);
    check("R11 queue drained", sbQ.size(), 32'd0);
    report();
  end

endmodule